// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block fetches the source operand of a register-memory ALU instruction. A command carries an addressing mode, a base register number, an index register number, a 16-bit constant and a 2-bit element-size code. The block reads the base and index values from its own small register file and forms an effective address. It then performs zero, one or two memory reads through a request/valid port. At the end it presents the operand together with a one-cycle done strobe.

The auto-increment and auto-decrement modes also update the base register by the element size. That update is committed in the same cycle as the done strobe. An external load port fills the register file. Commands are accepted only while the block is idle. A memory read keeps its request and address steady until the memory answers, however long that takes.

Top module: `oprsv_top`

## Requirements
- R1: Mode code 0 (register) and the unused codes 10 to 15 return the contents of the base register without issuing any memory request.
- R2: Mode code 1 (immediate) returns the 16-bit constant sign-extended to 32 bits, without issuing any memory request.
- R3: Mode code 2 (displacement) performs one read at the sign-extended constant plus the base register.
- R4: Mode code 3 (register deferred) performs one read at the base register value. Mode code 5 (absolute) performs one read at the sign-extended constant.
- R5: Mode code 4 (indexed) performs one read at the base register plus the index register.
- R6: Mode code 6 (double indirect) performs two reads. The first is at the base register value, the second is at the data returned by the first, and the operand is the data of the second.
- R7: Mode code 7 (post-increment) reads at the base register value and then adds the element size to the base register.
- R8: Mode code 8 (pre-decrement) subtracts the element size from the base register and reads at the decremented value, which is also written back.
- R9: Mode code 9 (scaled) performs one read at the sign-extended constant plus the base register plus the index register multiplied by the element size.
- R10: A command is accepted only on a cycle where cmd_valid and cmd_ready are both high. cmd_ready is high only when the block is idle, and cmd_valid is ignored while the block is busy.
- R11: A read keeps mem_req high and mem_addr unchanged until mem_valid is seen. mem_rdata is taken in the cycle where mem_req and mem_valid are both high.
- R12: done is high for exactly one cycle with no memory request in that cycle, and any base write-back happens in that cycle. If an external load targets the same register in that cycle, the write-back wins. A load to any other register in that cycle takes effect.
- R13: The size code selects the element size: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. Scaling is a left shift of the index by the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be accepted |
| cmd_mode | input | 4 | Addressing mode code |
| cmd_base | input | 3 | Base register number |
| cmd_index | input | 3 | Index register number |
| cmd_const | input | 16 | Displacement or immediate constant |
| cmd_size | input | 2 | Element size code |
| rf_we | input | 1 | External register load enable |
| rf_waddr | input | 3 | External load register number |
| rf_wdata | input | 32 | External load value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | Operand ready strobe |
| operand | output | 32 | Resolved operand value, meaningful with done |

## Verification
Two functions can fall in the same cycle. The base write-back of a post-increment or pre-decrement command lands in the done cycle, and an external register load can arrive in that same cycle. The bench watches for done and drives the load port in that cycle, once aimed at the base register and once at a different register. It then reads both registers back through register mode. The expected result is the write-back value in the first case and the loaded value in the second.

// File: rtl/oprsv_pkg.sv
package oprsv_pkg;

   typedef enum logic [3:0] {
      AM_REG    = 4'd0,
      AM_IMM    = 4'd1,
      AM_DISP   = 4'd2,
      AM_DEFER  = 4'd3,
      AM_INDEX  = 4'd4,
      AM_ABS    = 4'd5,
      AM_DINDIR = 4'd6,
      AM_POSTIN = 4'd7,
      AM_PREDEC = 4'd8,
      AM_SCALED = 4'd9
   } amode_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD1  = 2'd1,
      ST_RD2  = 2'd2,
      ST_FIN  = 2'd3
   } ostate_t;

   typedef struct packed {
      logic use_mem;
      logic chained;
      logic wb_en;
   } aflags_t;

endpackage

// File: rtl/oprsv_regfile.sv
module oprsv_regfile #(
   parameter int NREG      = 8,
   parameter int DW        = 32,
   parameter bit RST_CLEAR = 1'b1,
   localparam int RAW      = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ext_we,
   input  logic [RAW-1:0] ext_addr,
   input  logic [DW-1:0]  ext_data,
   input  logic           wb_we,
   input  logic [RAW-1:0] wb_addr,
   input  logic [DW-1:0]  wb_data,
   input  logic [RAW-1:0] rd_a_addr,
   output logic [DW-1:0]  rd_a_data,
   input  logic [RAW-1:0] rd_b_addr,
   output logic [DW-1:0]  rd_b_data
);

   logic [DW-1:0] regs [NREG];
   logic [DW-1:0] nxt  [NREG];

   // write-back from the sequencer takes precedence over an external load
   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         nxt[i] = regs[i];
         if (wb_we && (wb_addr == RAW'(i)))
            nxt[i] = wb_data;
         else if (ext_we && (ext_addr == RAW'(i)))
            nxt[i] = ext_data;
      end
   end

   generate
      if (RST_CLEAR) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else begin
               for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
         end
      end
   endgenerate

   assign rd_a_data = regs[rd_a_addr];
   assign rd_b_data = regs[rd_b_addr];

endmodule

// File: rtl/oprsv_agu.sv
module oprsv_agu
   import oprsv_pkg::*;
#(
   parameter int AW      = 32,
   parameter int CW      = 16,
   parameter int SZW     = 2
) (
   input  logic [3:0]     mode,
   input  logic [AW-1:0]  base_v,
   input  logic [AW-1:0]  idx_v,
   input  logic [CW-1:0]  cst,
   input  logic [SZW-1:0] size,
   output logic [AW-1:0]  ea,
   output logic [AW-1:0]  wb_val,
   output logic [AW-1:0]  direct_val,
   output aflags_t        flags
);

   localparam int EXT = AW - CW;

   logic [AW-1:0] sx;
   logic [AW-1:0] elem;
   logic [AW-1:0] scaled_idx;

   generate
      if (EXT > 0) begin : g_ext
         assign sx = {{EXT{cst[CW-1]}}, cst};
      end else begin : g_noext
         assign sx = cst[AW-1:0];
      end
   endgenerate

   assign elem       = AW'(1) << size;
   assign scaled_idx = idx_v << size;

   always_comb begin
      ea         = base_v;
      wb_val     = base_v;
      direct_val = base_v;
      flags      = '{use_mem: 1'b1, chained: 1'b0, wb_en: 1'b0};
      case (amode_t'(mode))
         AM_IMM: begin
            direct_val    = sx;
            flags.use_mem = 1'b0;
         end
         AM_DISP:   ea = sx + base_v;
         AM_DEFER:  ea = base_v;
         AM_INDEX:  ea = base_v + idx_v;
         AM_ABS:    ea = sx;
         AM_DINDIR: begin
            ea            = base_v;
            flags.chained = 1'b1;
         end
         AM_POSTIN: begin
            ea          = base_v;
            wb_val      = base_v + elem;
            flags.wb_en = 1'b1;
         end
         AM_PREDEC: begin
            ea          = base_v - elem;
            wb_val      = base_v - elem;
            flags.wb_en = 1'b1;
         end
         AM_SCALED: ea = sx + base_v + scaled_idx;
         default: begin
            direct_val    = base_v;
            flags.use_mem = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/oprsv_ctrl.sv
module oprsv_ctrl
   import oprsv_pkg::*;
#(
   parameter int AW  = 32,
   parameter int RAW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   output logic           cmd_ready,
   input  logic [RAW-1:0] cmd_base,
   input  logic [AW-1:0]  ea_in,
   input  logic [AW-1:0]  wb_in,
   input  logic [AW-1:0]  direct_in,
   input  aflags_t        flags_in,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_valid,
   input  logic [AW-1:0]  mem_rdata,
   output logic           done,
   output logic [AW-1:0]  operand,
   output logic           wb_we,
   output logic [RAW-1:0] wb_addr,
   output logic [AW-1:0]  wb_data
);

   ostate_t        st;
   logic [AW-1:0]  addr_q;
   logic [AW-1:0]  wbv_q;
   logic [AW-1:0]  res_q;
   logic [RAW-1:0] breg_q;
   logic           wben_q;
   logic           chain_q;
   logic           accept;

   assign accept = cmd_valid && (st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr_q  <= '0;
         wbv_q   <= '0;
         res_q   <= '0;
         breg_q  <= '0;
         wben_q  <= 1'b0;
         chain_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  addr_q  <= ea_in;
                  wbv_q   <= wb_in;
                  res_q   <= direct_in;
                  breg_q  <= cmd_base;
                  wben_q  <= flags_in.wb_en;
                  chain_q <= flags_in.chained;
                  st      <= flags_in.use_mem ? ST_RD1 : ST_FIN;
               end
            end
            ST_RD1: begin
               if (mem_valid) begin
                  if (chain_q) begin
                     addr_q <= mem_rdata;
                     st     <= ST_RD2;
                  end else begin
                     res_q <= mem_rdata;
                     st    <= ST_FIN;
                  end
               end
            end
            ST_RD2: begin
               if (mem_valid) begin
                  res_q <= mem_rdata;
                  st    <= ST_FIN;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready = (st == ST_IDLE);
   assign mem_req   = (st == ST_RD1) || (st == ST_RD2);
   assign mem_addr  = addr_q;
   assign done      = (st == ST_FIN);
   assign operand   = res_q;
   assign wb_we     = (st == ST_FIN) && wben_q;
   assign wb_addr   = breg_q;
   assign wb_data   = wbv_q;

endmodule

// File: rtl/oprsv_top.sv
module oprsv_top
   import oprsv_pkg::*;
#(
   parameter int NREG      = 8,
   parameter int AW        = 32,
   parameter int CW        = 16,
   parameter int SZW       = 2,
   parameter bit RST_CLEAR = 1'b1,
   localparam int RAW      = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   output logic           cmd_ready,
   input  logic [3:0]     cmd_mode,
   input  logic [RAW-1:0] cmd_base,
   input  logic [RAW-1:0] cmd_index,
   input  logic [CW-1:0]  cmd_const,
   input  logic [SZW-1:0] cmd_size,
   input  logic           rf_we,
   input  logic [RAW-1:0] rf_waddr,
   input  logic [AW-1:0]  rf_wdata,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_valid,
   input  logic [AW-1:0]  mem_rdata,
   output logic           done,
   output logic [AW-1:0]  operand
);

   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("oprsv_top: NREG must be a power of two of at least 2");
      end
      if (CW > AW || CW < 2) begin : g_bad_cw
         $error("oprsv_top: CW must lie between 2 and AW");
      end
      if (SZW < 1 || SZW > 3) begin : g_bad_szw
         $error("oprsv_top: SZW must lie between 1 and 3");
      end
   endgenerate

   logic [AW-1:0]  base_v, idx_v;
   logic [AW-1:0]  ea, wb_val, direct_val;
   aflags_t        flags;
   logic           wb_we;
   logic [RAW-1:0] wb_addr;
   logic [AW-1:0]  wb_data;

   oprsv_regfile #(.NREG(NREG), .DW(AW), .RST_CLEAR(RST_CLEAR)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_we    (rf_we),
      .ext_addr  (rf_waddr),
      .ext_data  (rf_wdata),
      .wb_we     (wb_we),
      .wb_addr   (wb_addr),
      .wb_data   (wb_data),
      .rd_a_addr (cmd_base),
      .rd_a_data (base_v),
      .rd_b_addr (cmd_index),
      .rd_b_data (idx_v)
   );

   oprsv_agu #(.AW(AW), .CW(CW), .SZW(SZW)) u_agu (
      .mode       (cmd_mode),
      .base_v     (base_v),
      .idx_v      (idx_v),
      .cst        (cmd_const),
      .size       (cmd_size),
      .ea         (ea),
      .wb_val     (wb_val),
      .direct_val (direct_val),
      .flags      (flags)
   );

   oprsv_ctrl #(.AW(AW), .RAW(RAW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_base  (cmd_base),
      .ea_in     (ea),
      .wb_in     (wb_val),
      .direct_in (direct_val),
      .flags_in  (flags),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_valid (mem_valid),
      .mem_rdata (mem_rdata),
      .done      (done),
      .operand   (operand),
      .wb_we     (wb_we),
      .wb_addr   (wb_addr),
      .wb_data   (wb_data)
   );

endmodule

// File: rtl/oprsv_check.sv
module oprsv_check #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [3:0]    cmd_mode,
   input logic          mem_req,
   input logic          mem_valid,
   input logic [AW-1:0] mem_addr,
   input logic          done
);

   assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_nomem_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cmd_ready);

   // R1 and R2: register and immediate modes finish with no memory request
   assert_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && (cmd_mode == 4'd0 || cmd_mode == 4'd1))
      |=> (done && !mem_req));

endmodule

bind oprsv_top oprsv_check #(.AW(AW)) u_oprsv_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_mode  (cmd_mode),
   .mem_req   (mem_req),
   .mem_valid (mem_valid),
   .mem_addr  (mem_addr),
   .done      (done)
);

// File: tb/oprsv_top_test.sv
`timescale 1ns/100ps
module oprsv_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [3:0]  cmd_mode = '0;
   logic [2:0]  cmd_base = '0;
   logic [2:0]  cmd_index = '0;
   logic [15:0] cmd_const = '0;
   logic [1:0]  cmd_size = '0;
   logic        rf_we = 1'b0;
   logic [2:0]  rf_waddr = '0;
   logic [31:0] rf_wdata = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic [31:0] operand;

   always #2.5 clk = ~clk;

   oprsv_top uut (.*);

   typedef struct {
      logic [31:0] opnd;
      int          nreads;
      logic [31:0] addr1;
      logic [31:0] addr2;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] shadow [8];
   int          checks = 0;
   int          failures = 0;
   int          done_cnt = 0;
   int          lat = 0;
   int          wcnt = 0;
   int          reads_seen = 0;
   bit          coll_en = 0;
   bit          coll_drv = 0;
   logic [2:0]  coll_reg;
   logic [31:0] coll_val;

   function automatic logic [31:0] mf(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor and memory model share one process to keep ordering fixed
   always @(negedge clk) begin
      if (coll_drv) begin
         rf_we    = 1'b0;
         coll_drv = 0;
      end
      if (done) begin
         done_cnt++;
         if (sb.size() == 0) begin
            chk("R10 unexpected done", 32'd1, 32'd0);
         end else begin
            chk({sb[0].tag, " operand"}, operand, sb[0].opnd);
            chk({sb[0].tag, " read count"}, reads_seen, sb[0].nreads);
            void'(sb.pop_front());
         end
         reads_seen = 0;
         if (coll_en) begin
            rf_we    = 1'b1;
            rf_waddr = coll_reg;
            rf_wdata = coll_val;
            coll_en  = 0;
            coll_drv = 1;
         end
      end
      if (mem_req && !mem_valid) begin
         if (wcnt >= lat) begin
            if (sb.size() != 0)
               chk({sb[0].tag, " R11 address"}, mem_addr,
                   (reads_seen == 0) ? sb[0].addr1 : sb[0].addr2);
            mem_valid = 1'b1;
            mem_rdata = mf(mem_addr);
            wcnt = 0;
            reads_seen++;
         end else begin
            wcnt++;
         end
      end else begin
         mem_valid = 1'b0;
      end
   end

   task automatic load_reg(input logic [2:0] r, input logic [31:0] v);
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = r; rf_wdata = v;
      @(negedge clk);
      rf_we = 1'b0;
      shadow[r] = v;
   endtask

   task automatic issue(input logic [3:0] m, input logic [2:0] b, input logic [2:0] x,
                        input logic [15:0] c, input logic [1:0] s, input string tag,
                        input bit intrude);
      exp_t e;
      logic [31:0] sx, d, bv, xv;
      int start;
      sx = {{16{c[15]}}, c};
      d  = 32'd1 << s;
      bv = shadow[b];
      xv = shadow[x];
      e.tag = tag; e.nreads = 1; e.addr2 = '0;
      case (m)
         4'd1: begin e.opnd = sx; e.nreads = 0; e.addr1 = '0; end
         4'd2: e.addr1 = sx + bv;
         4'd3: e.addr1 = bv;
         4'd4: e.addr1 = bv + xv;
         4'd5: e.addr1 = sx;
         4'd6: begin e.addr1 = bv; e.addr2 = mf(bv); e.nreads = 2; end
         4'd7: begin e.addr1 = bv; shadow[b] = bv + d; end
         4'd8: begin e.addr1 = bv - d; shadow[b] = bv - d; end
         4'd9: e.addr1 = sx + bv + (xv << s);
         default: begin e.opnd = bv; e.nreads = 0; e.addr1 = '0; end
      endcase
      if (e.nreads == 1) e.opnd = mf(e.addr1);
      if (e.nreads == 2) e.opnd = mf(e.addr2);
      sb.push_back(e);
      start = done_cnt;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_mode = m; cmd_base = b; cmd_index = x; cmd_const = c; cmd_size = s;
      cmd_valid = 1'b1;
      @(negedge clk);
      if (intrude) begin
         // offer a register-mode command while busy: it must be ignored
         cmd_mode = 4'd0; cmd_base = 3'd7;
         chk("R10 busy ready low", {31'd0, cmd_ready}, 32'd0);
         @(negedge clk);
         chk("R10 busy ready low", {31'd0, cmd_ready}, 32'd0);
      end
      cmd_valid = 1'b0;
      while (done_cnt == start) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      chk("reset R10 cmd_ready", {31'd0, cmd_ready}, 32'd1);
      chk("reset R11 mem_req", {31'd0, mem_req}, 32'd0);
      chk("reset R12 done", {31'd0, done}, 32'd0);
      rst_n = 1'b1;

      load_reg(3'd1, 32'h0000_1000);
      load_reg(3'd2, 32'h0000_0020);
      load_reg(3'd3, 32'hFFFF_FFF0);
      load_reg(3'd4, 32'h0000_0003);
      load_reg(3'd5, 32'h8000_0000);
      load_reg(3'd6, 32'h0000_0400);

      lat = 0;
      issue(4'd0,  3'd1, 3'd0, 16'h0000, 2'd0, "R1 register mode", 0);
      issue(4'd12, 3'd5, 3'd0, 16'h1234, 2'd0, "R1 unused code", 0);
      issue(4'd1,  3'd0, 3'd0, 16'h8001, 2'd0, "R2 negative immediate", 0);
      issue(4'd1,  3'd0, 3'd0, 16'h7FFF, 2'd0, "R2 positive immediate", 0);
      issue(4'd2,  3'd1, 3'd0, 16'hFFFC, 2'd0, "R3 negative displacement", 0);
      issue(4'd2,  3'd5, 3'd0, 16'h0100, 2'd0, "R3 positive displacement", 0);
      issue(4'd3,  3'd3, 3'd0, 16'h0000, 2'd0, "R4 deferred", 0);
      issue(4'd5,  3'd0, 3'd0, 16'h9000, 2'd0, "R4 absolute", 0);
      issue(4'd4,  3'd1, 3'd2, 16'h0000, 2'd0, "R5 indexed", 0);

      lat = 2;
      issue(4'd6,  3'd1, 3'd0, 16'h0000, 2'd0, "R6 double indirect", 0);
      issue(4'd7,  3'd1, 3'd0, 16'h0000, 2'd2, "R7 post-increment size 4", 0);
      issue(4'd0,  3'd1, 3'd0, 16'h0000, 2'd0, "R7 base after increment", 0);
      issue(4'd7,  3'd6, 3'd0, 16'h0000, 2'd3, "R7 R13 post-increment size 8", 0);
      issue(4'd0,  3'd6, 3'd0, 16'h0000, 2'd0, "R7 R13 base after increment", 0);
      issue(4'd8,  3'd2, 3'd0, 16'h0000, 2'd0, "R8 pre-decrement size 1", 0);
      issue(4'd0,  3'd2, 3'd0, 16'h0000, 2'd0, "R8 base after decrement", 0);
      issue(4'd8,  3'd3, 3'd0, 16'h0000, 2'd1, "R8 R13 pre-decrement size 2", 0);
      issue(4'd0,  3'd3, 3'd0, 16'h0000, 2'd0, "R8 R13 base after decrement", 0);

      lat = 1;
      for (int s = 0; s < 4; s++)
         issue(4'd9, 3'd1, 3'd4, 16'hFFF0, 2'(s), "R9 R13 scaled", 0);

      lat = 3;
      issue(4'd3,  3'd6, 3'd0, 16'h0000, 2'd0, "R11 slow memory", 0);
      issue(4'd6,  3'd5, 3'd0, 16'h0000, 2'd0, "R11 R6 slow double read", 0);
      issue(4'd2,  3'd1, 3'd0, 16'h0040, 2'd0, "R10 ignored while busy", 1);
      issue(4'd0,  3'd7, 3'd0, 16'h0000, 2'd0, "R10 r7 untouched", 0);

      lat = 0;
      coll_reg = 3'd1; coll_val = 32'hDEAD_0001; coll_en = 1;
      issue(4'd7, 3'd1, 3'd0, 16'h0000, 2'd1, "R12 collision same reg", 0);
      issue(4'd0, 3'd1, 3'd0, 16'h0000, 2'd0, "R12 write-back wins", 0);
      coll_reg = 3'd4; coll_val = 32'h0BAD_F00D; coll_en = 1;
      issue(4'd8, 3'd6, 3'd0, 16'h0000, 2'd2, "R12 collision other reg", 0);
      shadow[4] = 32'h0BAD_F00D;
      issue(4'd0, 3'd4, 3'd0, 16'h0000, 2'd0, "R12 other load lands", 0);
      issue(4'd0, 3'd6, 3'd0, 16'h0000, 2'd0, "R12 base after decrement", 0);

      repeat (5) @(negedge clk);
      chk("R10 all commands completed", sb.size(), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule